// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the address sequence of a four-beat burst for a synchronous burst memory. A burst begins when one of two active-low address strobes is sampled low at a clock edge while all three chip enables are active. Either the processor strobe or the controller strobe can start it. At that edge the full presented address is captured. The upper address bits are then held for the whole burst. The two lowest bits are produced by a two-bit wrapping beat counter, which moves forward only on edges where the active-low advance input is low.

A static order-select input picks how the beat counter maps onto the low address bits. When it is low, the order is linear wraparound: the start plus the beat, modulo four. When it is high, the order is interleaved: the start XOR the beat. An unconnected select should be tied high by the integration, which gives interleaved order. The block also reports the current beat index and flags the final beat of the four. Arbitration between the two strobes follows a fixed rule. The processor strobe wins, and it is blocked when the first chip enable is inactive.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and at the first edge after it, addr_o is all zeros, beat_o is 0 and last_o is 0.
- R2: A load happens at a clock edge when sel1_n=0, sel2=1, sel3_n=0 and either pstb_n=0 or cstb_n=0. After that edge, addr_o equals addr_in as sampled and beat_o is 0.
- R3: A load is not taken while any chip enable is inactive: sel1_n=1, sel2=0 or sel3_n=1. A processor strobe with sel1_n=1 therefore leaves the upper bits of addr_o unchanged.
- R4: When an edge does not load and adv_n=0, beat_o increments by one, wrapping from 3 to 0.
- R5: When an edge does not load and adv_n=1, addr_o and beat_o keep their values.
- R6: With order_sel=0 (linear), addr_o[1:0] equals (start + beat_o) mod 4, where start is the loaded addr_in[1:0].
- R7: With order_sel=1 (interleaved), addr_o[1:0] equals start XOR beat_o.
- R8: addr_o[ADDR_W-1:2] changes only at a load.
- R9: A load takes priority over advance. A strobe in the middle of a burst restarts the burst at beat 0 from the newly presented address.
- R10: When pstb_n and cstb_n are both low with all enables active, exactly one load of addr_in occurs and beat_o becomes 0. The processor strobe is the one taken.
- R11: last_o is 1 exactly when beat_o is 3. After four advances from a load, addr_o is back at the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 1 | Static order strap: 0 selects linear, 1 selects interleaved |
| sel1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip enable, active high |
| sel3_n | input | 1 | Third chip enable, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_in | input | ADDR_W | Address presented with a strobe |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index, 0 to 3 |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench walks every start value in both orders through four beats and one wrap. A design that swapped the orders, or that added where it should XOR, would give wrong low bits on starts 1 and 3. A design that saturated instead of wrapping would not return to the start address. Further tests apply a processor strobe with the first enable inactive, disable each of the other enables, and hold advance high. A design that skipped any enable term would reload the upper bits, and one that ignored the advance input would drift. Other tests fire a strobe in the middle of a burst and assert both strobes at once. A design that let advance win would keep the old upper bits or a nonzero beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // linear: wrap the sum of start and beat
  function automatic beat_t order_lin(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // interleaved: flip start bits selected by the beat
  function automatic beat_t order_xor(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction

  function automatic beat_t order_map(beat_t start, beat_t beat, logic intl);
    return intl ? order_xor(start, beat) : order_lin(start, beat);
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (clr)  beat <= '0;
    else if (step) beat <= beat_t'(beat + beat_t'(1));
  end
endmodule

// File: rtl/burst_addr_latch.sv
module burst_addr_latch
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int HI_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   hi_q,
  output beat_t             start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
    end else if (ld) begin
      hi_q    <= addr_in[ADDR_W-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic  intl,
  input  beat_t start,
  input  beat_t beat,
  output beat_t low
);
  always_comb low = order_map(start, beat, intl);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o,
  output logic              last_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  // named events for the checker
  logic chip_on, p_take, c_take, ld_ev, adv_ev;
  assign chip_on = !sel1_n && sel2 && !sel3_n;
  assign p_take  = chip_on && !pstb_n;            // processor strobe wins
  assign c_take  = chip_on && !cstb_n && !p_take;
  assign ld_ev   = p_take || c_take;
  assign adv_ev  = !ld_ev && !adv_n;

  logic [HI_W-1:0] hi_q;
  beat_t start_q, beat_q, low_w;

  burst_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ld(ld_ev), .addr_in(addr_in),
    .hi_q(hi_q), .start_q(start_q)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ld_ev), .step(adv_ev), .beat(beat_q)
  );

  burst_order_map u_map (
    .intl(order_sel), .start(start_q), .beat(beat_q), .low(low_w)
  );

  assign addr_o = {hi_q, low_w};
  assign beat_o = beat_q;
  assign last_o = (beat_q == beat_t'(3));
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              order_sel,
  input logic              sel1_n,
  input logic              pstb_n,
  input logic              cstb_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o,
  input logic              last_o,
  input logic              ld_ev,
  input logic              adv_ev
);
  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ev |=> (addr_o == $past(addr_in)) && (beat_o == 2'd0));

  a_r3_blocked_pstb: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n && !pstb_n && cstb_n) |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> beat_o == 2'($past(beat_o) + 2'd1));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ev && adv_n && $stable(order_sel)) |=> $stable(addr_o) && $stable(beat_o));

  a_r6_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && !order_sel) ##1 (!order_sel && $stable(order_sel))
      |-> addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1));

  a_r7_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && order_sel) ##1 (order_sel && $stable(order_sel))
      |-> (addr_o[1:0] ^ $past(addr_o[1:0])) == (beat_o ^ $past(beat_o)));

  a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ev |=> $stable(addr_o[ADDR_W-1:2]));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ev && !adv_n) |=> beat_o == 2'd0);

  a_r11_last_flag: assert property (@(posedge clk) disable iff (!rst_n)
    last_o == (beat_o == 2'd3));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .sel1_n(sel1_n),
  .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .addr_in(addr_in),
  .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o),
  .ld_ev(ld_ev), .adv_ev(adv_ev)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 16;
  // {order, start, beat0..beat3 low bits}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 8'b00_01_10_11},
    {1'b0, 2'd1, 8'b01_10_11_00},
    {1'b0, 2'd2, 8'b10_11_00_01},
    {1'b0, 2'd3, 8'b11_00_01_10},
    {1'b1, 2'd0, 8'b00_01_10_11},
    {1'b1, 2'd1, 8'b01_00_11_10},
    {1'b1, 2'd2, 8'b10_11_00_01},
    {1'b1, 2'd3, 8'b11_10_01_00}
  };

  logic clk = 0, rst_n = 0, order_sel = 1;
  logic sel1_n = 0, sel2 = 1, sel3_n = 0, pstb_n = 1, cstb_n = 1, adv_n = 1;
  logic [AW-1:0] addr_in = '0, addr_o;
  logic [1:0] beat_o;
  logic last_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .adv_n(adv_n), .addr_in(addr_in), .addr_o(addr_o), .beat_o(beat_o),
    .last_o(last_o)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, return just after the next rising edge
  task automatic cyc(logic p, logic c, logic a, logic [AW-1:0] ad);
    @(negedge clk);
    pstb_n = p; cstb_n = c; adv_n = a; addr_in = ad;
    @(posedge clk); #1;
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset addr", addr_o, '0);
    chk("R1 reset beat", AW'(beat_o), '0);
    cyc(1, 1, 1, '0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", {addr_o[AW-2:0], last_o}, '0);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      @(negedge clk); order_sel = v[10];
      base = {AW'(16'h1A4 + 16'(i * 37)) & ~AW'(3)} | AW'(v[9:8]);
      if (i % 2 == 0) cyc(0, 1, 1, base);   // R2 processor strobe
      else            cyc(1, 0, 1, base);   // R2 controller strobe
      chk("R2 load addr", addr_o, base);
      chk("R2 load beat", AW'(beat_o), '0);
      for (int b = 1; b < 4; b++) begin
        cyc(1, 1, 0, '1);
        chk(v[10] ? "R7 interleave low" : "R6 linear low",
            AW'(addr_o[1:0]), AW'(v[7 - 2*b -: 2]));
        chk("R8 upper hold", addr_o >> 2, base >> 2);
        chk("R4/R11 beat+last", AW'({beat_o, last_o}), AW'({2'(b), b == 3}));
      end
      cyc(1, 1, 0, '1);
      chk("R11 wrap to start", addr_o, base);
    end

    // R5 hold with advance high
    @(negedge clk); order_sel = 0;
    cyc(1, 0, 1, 16'h4C81);
    cyc(1, 1, 0, '0);
    cyc(1, 1, 1, '0);
    cyc(1, 1, 1, '0);
    chk("R5 hold addr", addr_o, 16'h4C82);
    chk("R5 hold beat", AW'(beat_o), 1);

    // R3 processor strobe with first enable inactive
    @(negedge clk); sel1_n = 1;
    cyc(0, 1, 1, 16'hFFFF);
    chk("R3 sel1 blocks pstb", addr_o, 16'h4C82);
    @(negedge clk); sel1_n = 0; sel2 = 0;
    cyc(1, 0, 1, 16'hFFFF);
    chk("R3 sel2 blocks", addr_o, 16'h4C82);
    @(negedge clk); sel2 = 1; sel3_n = 1;
    cyc(0, 0, 1, 16'hFFFF);
    chk("R3 sel3 blocks", addr_o, 16'h4C82);
    @(negedge clk); sel3_n = 0;

    // R9 restart mid-burst, load beats advance
    cyc(1, 1, 0, '0);
    cyc(0, 1, 0, 16'h0123);
    chk("R9 restart addr", addr_o, 16'h0123);
    chk("R9 restart beat", AW'(beat_o), '0);

    // R10 both strobes together, interleaved
    @(negedge clk); order_sel = 1;
    cyc(0, 0, 0, 16'h8006);
    chk("R10 both strobes addr", addr_o, 16'h8006);
    chk("R10 both strobes beat", AW'(beat_o), '0);
    cyc(1, 1, 0, '0);
    chk("R10 then R7 step", addr_o, 16'h8007);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule